// File: doc/BRIEF.md
# Temperature Limit Alarm Controller

This block watches a stream of signed temperature samples and raises two alarms. A sample is considered only in the cycle its conversion-done strobe is high. Each alarm has a trip limit and a lower release limit that adds hysteresis. The general interrupt alarm drives an active-low pin and a status bit. The over-temperature alarm drives a pin whose polarity software selects.

The interrupt alarm runs in one of two policies. In the repeating policy it latches on every conversion while the temperature stays in the tripped region, and it releases by itself once the temperature drops below the release limit. In the one-shot policy it latches once per excursion and re-arms only after the temperature has fallen below the release limit.

The over-temperature alarm runs either in the same one-shot policy or as a transparent comparator with hysteresis. A status read strobe or a software clear drops the latched state of both alarms. This clear has no effect on the comparator policy. All outputs are registered, so they change one clock after the strobe or clear that causes the change.

Top module: `temp_alarm_ctrl`

## Requirements
- R1: After reset, `int_n_o` is 1, `int_stat_o` is 0, both channels are armed and not tripped, and `ot_o` shows the inactive level for the selected polarity.
- R2: When `conv_done` is 0, `temp` has no effect on either alarm, whatever its value.
- R3: Comparisons are signed. A sample trips a channel only when it is strictly greater than the trip limit. In the repeating policy (`int_once`=0), a tripping sample sets the interrupt: `int_stat_o`=1 and `int_n_o`=0.
- R4: A pulse on `stat_rd` or on `sw_clr` clears the latched interrupt. In the repeating policy, the interrupt sets again on the next conversion whose sample is not strictly below `hot_hyst`, provided the channel tripped earlier and has not released since.
- R5: In the repeating policy, a conversion with a sample strictly below `hot_hyst` clears the interrupt. Later samples between the two limits do not set it again.
- R6: In the one-shot policy (`int_once`=1), a trip sets the interrupt once. After it is cleared, it does not set again until a sample has fallen strictly below `hot_hyst` and a later sample exceeds `hot_lim`.
- R7: In the one-shot policy, a sample below `hot_hyst` does not clear a latched interrupt. Only `stat_rd` or `sw_clr` clears it.
- R8: In comparator mode (`ot_cmp`=1), the over-temperature alarm is active from a conversion above `ot_lim` until a conversion strictly below `ot_hyst`. `stat_rd` and `sw_clr` do not change it.
- R9: With `ot_cmp`=0, the over-temperature alarm uses the one-shot policy. It is latched, cleared by `stat_rd` or `sw_clr`, and re-armed only by a sample below `ot_hyst`.
- R10: With `ot_act_high`=0, `ot_o` is low when the alarm is active. With `ot_act_high`=1, it is high when active. A change of `ot_act_high` takes effect on `ot_o` without a clock edge.
- R11: If a trip limit is programmed below its release limit, a sample that is both above the trip limit and below the release limit counts as a trip.
- R12: If a setting conversion and a clear arrive in the same cycle, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | Sample-valid strobe |
| temp | input | TW | Signed temperature sample |
| hot_lim | input | TW | Interrupt trip limit, signed |
| hot_hyst | input | TW | Interrupt release limit, signed |
| ot_lim | input | TW | Over-temperature trip limit, signed |
| ot_hyst | input | TW | Over-temperature release limit, signed |
| int_once | input | 1 | 1 selects the one-shot policy for the interrupt, 0 selects repeating |
| ot_cmp | input | 1 | 1 selects comparator mode for over-temperature, 0 selects one-shot |
| ot_act_high | input | 1 | Polarity of `ot_o` when active |
| stat_rd | input | 1 | Status read strobe, clears the latches |
| sw_clr | input | 1 | Software clear, clears the latches |
| int_n_o | output | 1 | Interrupt pin, active low |
| ot_o | output | 1 | Over-temperature pin |
| int_stat_o | output | 1 | Interrupt status bit, active high |

## Verification
The hardest state to reach from the ports is the one where the interrupt has been cleared but the channel is still tripped. In the repeating policy this state must fire again on a sample that lies between the limits. In the one-shot policy it must stay silent even on a sample above the trip limit. The stimulus reaches it by tripping the channel, clearing through the read strobe or the software clear, and then sending samples exactly at the release limit, between the limits and above the trip limit. The release then comes from one sample just below the release limit. Inverted limits and a clear that coincides with a setting conversion cover the priority rules.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;

  typedef enum logic [1:0] {
    MODE_REPEAT  = 2'd0,
    MODE_ONCE    = 2'd1,
    MODE_COMPARE = 2'd2
  } alarm_mode_e;

  // strict signed "greater than trip limit"
  function automatic logic f_exceeds(input logic signed [31:0] smp,
                                     input logic signed [31:0] lim);
    return smp > lim;
  endfunction

  // strict signed "less than release limit"
  function automatic logic f_under(input logic signed [31:0] smp,
                                   input logic signed [31:0] rel);
    return smp < rel;
  endfunction

  // drive a pin from an active flag and a polarity select
  function automatic logic f_pin(input logic active, input logic act_high);
    return act_high ? active : ~active;
  endfunction

endpackage

// File: rtl/limit_cmp.sv
module limit_cmp #(
  parameter int TW = 8
) (
  input  logic signed [TW-1:0] smp,
  input  logic signed [TW-1:0] trip_lim,
  input  logic signed [TW-1:0] rel_lim,
  output logic                 above,
  output logic                 below
);
  import temp_alarm_pkg::*;

  always_comb begin
    above = f_exceeds(32'(smp), 32'(trip_lim));
    below = f_under(32'(smp), 32'(rel_lim));
  end

  // with ordered limits a sample can never be on both sides (R11 context)
  always_comb begin
    if (trip_lim >= rel_lim)
      assert_disjoint_R11: assert (!(above && below));
  end

endmodule

// File: rtl/alarm_latch.sv
module alarm_latch (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        conv,
  input  logic                        above,
  input  logic                        below,
  input  logic                        clr,
  input  temp_alarm_pkg::alarm_mode_e mode,
  output logic                        active
);
  import temp_alarm_pkg::*;

  logic pend_q, tripped_q;
  logic fire_ev, release_ev, pend_d, tripped_d;

  // internal events, named for the assertions
  always_comb begin
    fire_ev = 1'b0;
    if (conv) begin
      unique case (mode)
        MODE_REPEAT:  fire_ev = above | (tripped_q & ~below);
        MODE_ONCE:    fire_ev = above & ~tripped_q;
        default:      fire_ev = 1'b0;
      endcase
    end
    release_ev = conv & below & ~above & (mode == MODE_REPEAT);
  end

  always_comb begin
    tripped_d = tripped_q;
    if (conv) begin
      if (above)      tripped_d = 1'b1;
      else if (below) tripped_d = 1'b0;
    end
    if (fire_ev)                 pend_d = 1'b1;
    else if (release_ev || clr)  pend_d = 1'b0;
    else                         pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      tripped_q <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      tripped_q <= tripped_d;
    end
  end

  assign active = (mode == MODE_COMPARE) ? tripped_q : pend_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !conv && !clr |=> $stable(pend_q) && $stable(tripped_q));

  assert_rep_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv && above && mode == MODE_REPEAT |=> pend_q);

  assert_rep_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv && below && !above && mode == MODE_REPEAT |=> !pend_q);

  assert_once_no_refire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv && tripped_q && !clr && mode == MODE_ONCE |=> $stable(pend_q));

  assert_cmp_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv && below && !above |=> !tripped_q);

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv && above && clr && mode == MODE_REPEAT |=> pend_q);

endmodule

// File: rtl/temp_alarm_ctrl.sv
module temp_alarm_ctrl #(
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_done,
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] hot_lim,
  input  logic signed [TW-1:0] hot_hyst,
  input  logic signed [TW-1:0] ot_lim,
  input  logic signed [TW-1:0] ot_hyst,
  input  logic                 int_once,
  input  logic                 ot_cmp,
  input  logic                 ot_act_high,
  input  logic                 stat_rd,
  input  logic                 sw_clr,
  output logic                 int_n_o,
  output logic                 ot_o,
  output logic                 int_stat_o
);
  import temp_alarm_pkg::*;

  localparam int NCH = 2;   // channel 0: interrupt, channel 1: over-temperature

  logic signed [TW-1:0] trip_v [NCH];
  logic signed [TW-1:0] rel_v  [NCH];
  alarm_mode_e          mode_v [NCH];
  logic                 above_v [NCH], below_v [NCH], act_v [NCH];
  logic                 clr_any;

  assign clr_any   = stat_rd | sw_clr;
  assign trip_v[0] = hot_lim;
  assign rel_v[0]  = hot_hyst;
  assign trip_v[1] = ot_lim;
  assign rel_v[1]  = ot_hyst;
  assign mode_v[0] = int_once ? MODE_ONCE : MODE_REPEAT;
  assign mode_v[1] = ot_cmp ? MODE_COMPARE : MODE_ONCE;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    limit_cmp #(.TW(TW)) u_cmp (
      .smp(temp), .trip_lim(trip_v[g]), .rel_lim(rel_v[g]),
      .above(above_v[g]), .below(below_v[g])
    );
    alarm_latch u_lat (
      .clk(clk), .rst_n(rst_n), .conv(conv_done),
      .above(above_v[g]), .below(below_v[g]), .clr(clr_any),
      .mode(mode_v[g]), .active(act_v[g])
    );
  end

  assign int_stat_o = act_v[0];
  assign int_n_o    = f_pin(act_v[0], 1'b0);
  assign ot_o       = f_pin(act_v[1], ot_act_high);

  // comparator output is untouched by a clear when no conversion arrives (R8)
  assert_cmp_ignores_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ot_cmp && clr_any && !conv_done && $stable(ot_act_high) ##1 ot_cmp && $stable(ot_act_high)
    |-> $stable(ot_o));

  // the pin and the status bit never disagree (R3)
  assert_pin_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_n_o != int_stat_o);

endmodule

// File: tb/sim_temp_alarm_ctrl.sv
module sim_temp_alarm_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_done = 1'b0;
  logic signed [7:0] temp = '0;
  logic signed [7:0] hot_lim = 8'sd50, hot_hyst = 8'sd40;
  logic signed [7:0] ot_lim = 8'sd80, ot_hyst = 8'sd70;
  logic int_once = 1'b0, ot_cmp = 1'b1, ot_act_high = 1'b0;
  logic stat_rd = 1'b0, sw_clr = 1'b0;
  logic int_n_o, ot_o, int_stat_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_alarm_ctrl #(.TW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp(temp),
    .hot_lim(hot_lim), .hot_hyst(hot_hyst), .ot_lim(ot_lim), .ot_hyst(ot_hyst),
    .int_once(int_once), .ot_cmp(ot_cmp), .ot_act_high(ot_act_high),
    .stat_rd(stat_rd), .sw_clr(sw_clr),
    .int_n_o(int_n_o), .ot_o(ot_o), .int_stat_o(int_stat_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // all tasks are entered and left at a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic conv(input logic signed [7:0] t);
    temp = t; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    sw_clr = 1'b1; @(negedge clk); sw_clr = 1'b0;
  endtask

  task automatic t_reset();
    ot_act_high = 1'b0;
    do_reset();
    check("R1 int pin", int_n_o, 1'b1);
    check("R1 status", int_stat_o, 1'b0);
    check("R1 ot pin", ot_o, 1'b1);
  endtask

  task automatic t_strobe();
    do_reset();
    temp = 8'sd120;
    repeat (3) @(negedge clk);
    check("R2 int ignores temp", int_stat_o, 1'b0);
    check("R2 ot ignores temp", ot_o, 1'b1);
    conv(8'sd10);
  endtask

  task automatic t_repeat();
    int_once = 1'b0; do_reset();
    conv(8'sd50);  check("R3 equal no trip", int_stat_o, 1'b0);
    conv(8'sd51);  check("R3 trip status", int_stat_o, 1'b1);
    check("R3 trip pin", int_n_o, 1'b0);
    conv(8'sd45);  check("R4 held", int_stat_o, 1'b1);
    pulse_rd();    check("R4 read clears", int_stat_o, 1'b0);
    conv(8'sd45);  check("R4 refire between", int_stat_o, 1'b1);
    pulse_clr();   check("R4 sw clear", int_stat_o, 1'b0);
    conv(8'sd40);  check("R4 refire at hyst", int_stat_o, 1'b1);
    conv(8'sd39);  check("R5 auto release", int_stat_o, 1'b0);
    conv(8'sd45);  check("R5 no refire after release", int_stat_o, 1'b0);
    hot_lim = -8'sd10; hot_hyst = -8'sd20; do_reset();
    conv(-8'sd5);  check("R3 signed trip", int_stat_o, 1'b1);
    conv(-8'sd25); check("R5 signed release", int_stat_o, 1'b0);
    hot_lim = 8'sd50; hot_hyst = 8'sd40;
  endtask

  task automatic t_once();
    int_once = 1'b1; do_reset();
    conv(8'sd60);  check("R6 trip", int_stat_o, 1'b1);
    conv(8'sd30);  check("R7 below keeps latch", int_stat_o, 1'b1);
    pulse_rd();    check("R7 read clears", int_stat_o, 1'b0);
    conv(8'sd60);  check("R6 rearmed trip", int_stat_o, 1'b1);
    pulse_rd();
    conv(8'sd60);  check("R6 no refire", int_stat_o, 1'b0);
    conv(8'sd45);  conv(8'sd60);
    check("R6 no refire above hyst", int_stat_o, 1'b0);
    conv(8'sd39);  check("R6 release no set", int_stat_o, 1'b0);
    conv(8'sd55);  check("R6 re-trip", int_stat_o, 1'b1);
    int_once = 1'b0;
  endtask

  task automatic t_compare();
    ot_cmp = 1'b1; ot_act_high = 1'b0; do_reset();
    conv(8'sd81);  check("R8 active", ot_o, 1'b0);
    conv(8'sd75);  check("R8 hold between", ot_o, 1'b0);
    pulse_rd();    check("R8 read ignored", ot_o, 1'b0);
    pulse_clr();   check("R8 clear ignored", ot_o, 1'b0);
    conv(8'sd70);  check("R8 at hyst holds", ot_o, 1'b0);
    conv(8'sd69);  check("R8 release", ot_o, 1'b1);
    conv(8'sd75);  check("R8 no reassert between", ot_o, 1'b1);
    ot_act_high = 1'b1; #1;
    check("R10 inactive high-pol", ot_o, 1'b0);
    @(negedge clk);
    conv(8'sd90);  check("R10 active high-pol", ot_o, 1'b1);
    ot_act_high = 1'b0; #1;
    check("R10 active low-pol", ot_o, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_ot_once();
    ot_cmp = 1'b0; ot_act_high = 1'b0; do_reset();
    conv(8'sd85);  check("R9 trip", ot_o, 1'b0);
    conv(8'sd60);  check("R9 latched below", ot_o, 1'b0);
    pulse_rd();    check("R9 read clears", ot_o, 1'b1);
    conv(8'sd85);  check("R9 rearmed trip", ot_o, 1'b0);
    pulse_clr();
    conv(8'sd85);  check("R9 no refire", ot_o, 1'b1);
    ot_cmp = 1'b1;
  endtask

  task automatic t_conflict();
    hot_lim = 8'sd30; hot_hyst = 8'sd40; int_once = 1'b0; do_reset();
    conv(8'sd35);  check("R11 both sides sets", int_stat_o, 1'b1);
    conv(8'sd20);  check("R11 plain release", int_stat_o, 1'b0);
    int_once = 1'b1; do_reset();
    conv(8'sd35);  check("R11 once both sides sets", int_stat_o, 1'b1);
    pulse_rd();
    conv(8'sd35);  check("R11 once no refire", int_stat_o, 1'b0);
    hot_lim = 8'sd50; hot_hyst = 8'sd40; int_once = 1'b0;
  endtask

  task automatic t_race();
    int_once = 1'b0; do_reset();
    temp = 8'sd60; conv_done = 1'b1; stat_rd = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; stat_rd = 1'b0;
    check("R12 set beats read", int_stat_o, 1'b1);
    temp = 8'sd60; conv_done = 1'b1; sw_clr = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; sw_clr = 1'b0;
    check("R12 set beats sw clear", int_stat_o, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_strobe();
    t_repeat();
    t_once();
    t_compare();
    t_ot_once();
    t_conflict();
    t_race();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule